// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital sequencer for a 12-bit successive-approximation converter in a small microcontroller. Software reaches it through two 8-bit registers. The mode register holds a clock-divider select and a resolution code. The control register holds a start/done flag and an analog channel number. The analog parts sit outside the block: the sample switch, the trial DAC and the comparator.

A conversion starts when software writes 1 to the start flag. The block then latches the divider and the channel. It derives a conversion clock by dividing the system clock by a power of two. Each conversion runs a fixed frame of 17 conversion-clock periods:

- one period of setup;
- one period of sampling;
- twelve periods of bit decisions, most significant bit first;
- one period to latch the result;
- two periods to signal completion.

During the decision periods the block drives a trial code to the DAC. It keeps or clears each trial bit according to the comparator level.

Top module: `sar_seq`

## Requirements
- R1: Mode bits [2:0] select the conversion-clock period as 2^n system clocks (n = 0..7). The divider restarts at the accepted start, so each frame step lasts exactly 2^n cycles.
- R2: `sample_o` is high for exactly one conversion-clock period. It rises 2^n cycles after the start write and is never high while the block is idle.
- R3: Control bit 6 reads 1 again exactly 17 x 2^n system cycles after the clock edge that accepts the start.
- R4: Writing 1 to control bit 6 starts a conversion. Bit 6 reads 0 while busy and 1 when idle, including after reset.
- R5: The result is found by successive approximation, most significant bit first. The first trial code is 0x800. A bit is kept when `cmp_i` is 1, and `cmp_i` means input >= trial. With an ideal comparator the result equals the input code. `result_o` changes only while busy and resets to 0.
- R6: Mode bits [7:5] must hold 100 for a start to be accepted. Otherwise the start is ignored and bit 6 stays 1. The mode register resets to 0x80 and reads back as written.
- R7: A start write while busy is ignored. The divider select and channel used by a running conversion are the ones latched at start, even if either register is rewritten.
- R8: Control bits [3:0] pick one of 10 channels, and `chan_sel_o` shows the latched channel. A value of 10 or more selects channel 0. Control bits [3:0] read back as written.
- R9: A start write in the same cycle that a conversion completes is ignored. No new frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode write data: [7:5] resolution code, [2:0] divider select |
| mode_rdata_o | output | 8 | Mode register contents |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 8 | Control write data: bit 6 start, [3:0] channel |
| ctrl_rdata_o | output | 8 | Control readback: bit 6 done/idle, others as written |
| sample_o | output | 1 | Sample switch enable |
| chan_sel_o | output | 4 | Latched analog channel select |
| dac_code_o | output | 12 | Trial code to the DAC |
| cmp_i | input | 1 | Comparator: 1 when input >= trial code |
| result_o | output | 12 | Last conversion result |

## Verification
A conversion can finish in the same system-clock cycle that software writes a new start. The bench provokes this by counting cycles from the start write and issuing a second start on the last busy cycle of a divided-by-4 frame. That write is judged correct only if the done flag reads 1 on the next cycle and stays 1, and `sample_o` never rises again for many cycles. A mid-frame start combined with rewrites of the divider and channel is judged in the same way: the frame length and `chan_sel_o` must match the values latched at the first start.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int REG_W = 8;
  localparam int START_BIT = 6;
  localparam logic [2:0] RES_CODE_12 = 3'b100;
  localparam logic [REG_W-1:0] MODE_RST = 8'h80;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ACQ,
    PH_DEC,
    PH_TAIL
  } phase_e;
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q, lim;

  always_comb lim = CNT_W'((32'd1 << sel_i) - 32'd1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (clr_i || !run_i || tick_o) cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_frame_ctl.sv
module sar_frame_ctl #(
  parameter int FRAME_LEN = 17,
  localparam int STEP_W = $clog2(FRAME_LEN)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] ST_LAST = STEP_W'(FRAME_LEN - 1);
  logic busy_q;
  logic [STEP_W-1:0] step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      step_q <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      step_q <= '0;
    end else if (busy_q && tick_i) begin
      if (step_q == ST_LAST) begin
        busy_q <= 1'b0;
        step_q <= '0;
      end else begin
        step_q <= step_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign step_o = step_q;
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_W = 12,
  localparam int BIT_W = $clog2(RES_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             decide_i,
  input  logic             latch_i,
  input  logic [BIT_W-1:0] bit_idx_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] trial_o,
  output logic [RES_W-1:0] result_o
);
  logic [RES_W-1:0] approx_q, result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 approx_q <= '0;
    else if (start_i)            approx_q <= '0;
    else if (decide_i && tick_i) approx_q[bit_idx_i] <= cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                result_q <= '0;
    else if (latch_i && tick_i) result_q <= approx_q;
  end

  // trial bit set on top of the bits already resolved
  for (genvar b = 0; b < RES_W; b++) begin : g_trial
    assign trial_o[b] = approx_q[b] | (decide_i && (bit_idx_i == BIT_W'(b)));
  end

  assign result_o = result_q;
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_seq_pkg::*;
#(
  parameter int RES_W  = 12,
  parameter int NUM_CH = 10,
  parameter int CH_W   = 4,
  parameter int SEL_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [7:0]       mode_wdata_i,
  output logic [7:0]       mode_rdata_o,
  input  logic             ctrl_wr_i,
  input  logic [7:0]       ctrl_wdata_i,
  output logic [7:0]       ctrl_rdata_o,
  output logic             sample_o,
  output logic [CH_W-1:0]  chan_sel_o,
  output logic [RES_W-1:0] dac_code_o,
  input  logic             cmp_i,
  output logic [RES_W-1:0] result_o
);
  localparam int DEC_FIRST = 2;
  localparam int DEC_LAST  = DEC_FIRST + RES_W - 1;
  localparam int LATCH_ST  = DEC_LAST + 1;
  localparam int FRAME_LEN = LATCH_ST + 3;
  localparam int STEP_W    = $clog2(FRAME_LEN);
  localparam int BIT_W     = $clog2(RES_W);
  localparam logic [STEP_W-1:0] ST_ACQ   = STEP_W'(1);
  localparam logic [STEP_W-1:0] ST_DEC0  = STEP_W'(DEC_FIRST);
  localparam logic [STEP_W-1:0] ST_DECN  = STEP_W'(DEC_LAST);
  localparam logic [STEP_W-1:0] ST_LATCH = STEP_W'(LATCH_ST);

  logic [7:0]        mode_q;
  logic [6:0]        ctrl_q;
  logic [SEL_W-1:0]  div_q;
  logic [CH_W-1:0]   ch_q;
  logic              start_req, start_ok, busy, tick;
  logic [STEP_W-1:0] step;
  logic [BIT_W-1:0]  bit_idx;
  phase_e            phase;

  assign start_req = ctrl_wr_i && ctrl_wdata_i[START_BIT];
  assign start_ok  = start_req && !busy && (mode_q[7:5] == RES_CODE_12);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= MODE_RST;
    else if (mode_wr_i) mode_q <= mode_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ctrl_q <= '0;
    else if (ctrl_wr_i) ctrl_q <= {ctrl_wdata_i[7], ctrl_wdata_i[5:0]};
  end

  // settings frozen for the whole frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      ch_q  <= '0;
    end else if (start_ok) begin
      div_q <= mode_q[SEL_W-1:0];
      ch_q  <= (int'(ctrl_wdata_i[CH_W-1:0]) < NUM_CH) ? ctrl_wdata_i[CH_W-1:0] : '0;
    end
  end

  sar_clk_div #(.SEL_W(SEL_W)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (start_ok),
    .run_i (busy),
    .sel_i (div_q),
    .tick_o(tick)
  );

  sar_frame_ctl #(.FRAME_LEN(FRAME_LEN)) i_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_ok),
    .tick_i (tick),
    .busy_o (busy),
    .step_o (step)
  );

  always_comb begin
    if (!busy)                                phase = PH_IDLE;
    else if (step == ST_ACQ)                  phase = PH_ACQ;
    else if (step >= ST_DEC0 && step <= ST_DECN) phase = PH_DEC;
    else                                      phase = PH_TAIL;
  end

  always_comb bit_idx = BIT_W'(DEC_LAST - int'(step));

  sar_approx #(.RES_W(RES_W)) i_approx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_ok),
    .tick_i   (tick),
    .decide_i (phase == PH_DEC),
    .latch_i  (busy && (step == ST_LATCH)),
    .bit_idx_i(bit_idx),
    .cmp_i    (cmp_i),
    .trial_o  (dac_code_o),
    .result_o (result_o)
  );

  assign sample_o     = (phase == PH_ACQ);
  assign chan_sel_o   = ch_q;
  assign mode_rdata_o = mode_q;
  assign ctrl_rdata_o = {ctrl_q[6], ~busy, ctrl_q[5:0]};
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W     = 12,
  parameter int CH_W      = 4,
  parameter int SEL_W     = 3,
  parameter int FRAME_LEN = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_i,
  input logic             done_i,
  input logic [RES_W-1:0] result_i,
  input logic [CH_W-1:0]  chan_i,
  input logic [2:0]       res_fld_i,
  input logic [SEL_W-1:0] div_i
);
  int samp_cnt, frm_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_cnt <= 0;
      frm_cnt  <= 0;
    end else begin
      samp_cnt <= sample_i ? samp_cnt + 1 : 0;
      frm_cnt  <= done_i ? 0 : frm_cnt + 1;
    end
  end

  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> !done_i); // R2
  AST_SAMPLE_ONE_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sample_i) |-> samp_cnt == (1 << div_i)); // R2
  AST_FRAME_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> frm_cnt == FRAME_LEN * (1 << div_i)); // R3
  AST_RESULT_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_i) |-> !done_i); // R5
  AST_BAD_RES_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && res_fld_i != 3'b100) |=> done_i); // R6
  AST_CHAN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_i && !$past(done_i)) |-> $stable(chan_i)); // R7
endmodule

bind sar_seq sar_seq_chk #(
  .RES_W(RES_W), .CH_W(CH_W), .SEL_W(SEL_W), .FRAME_LEN(FRAME_LEN)
) i_sar_seq_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sample_i (sample_o),
  .done_i   (ctrl_rdata_o[6]),
  .result_i (result_o),
  .chan_i   (chan_sel_o),
  .res_fld_i(mode_rdata_o[7:5]),
  .div_i    (div_q)
);

// File: tb/test_sar_seq.sv
module test_sar_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wr = 1'b0, ctrl_wr = 1'b0;
  logic [7:0]  mode_wdata = '0, ctrl_wdata = '0;
  logic [7:0]  mode_rdata, ctrl_rdata;
  logic        sample;
  logic [3:0]  chan_sel;
  logic [11:0] dac_code, result;
  logic [11:0] vin = '0;
  logic        cmp;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;
  assign cmp = (vin >= dac_code);

  sar_seq i_sar_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .mode_wr_i(mode_wr), .mode_wdata_i(mode_wdata), .mode_rdata_o(mode_rdata),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .sample_o(sample), .chan_sel_o(chan_sel), .dac_code_o(dac_code),
    .cmp_i(cmp), .result_o(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] v);
    @(negedge clk); mode_wr = 1'b1; mode_wdata = v;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  // one start write, then observe until done; n counts cycles after the accepting edge
  task automatic run_conv(input logic [3:0] ch, input int d, input bit disturb, input bit collide,
                          output int len, output int s_first, output int s_len,
                          output int first_trial, output bit chan_moved);
    int n;
    logic [3:0] ch0;
    s_first = -1; s_len = 0; first_trial = -1; chan_moved = 0; n = 0;
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 8'h40 | {4'h0, ch};
    @(negedge clk); ctrl_wr = 1'b0;
    chk(ctrl_rdata[6] == 1'b0, "R4 busy readback", ctrl_rdata[6], 0);
    ch0 = chan_sel;
    while (!ctrl_rdata[6] && n < 5000) begin
      if (sample && s_first < 0) s_first = n;
      if (sample) s_len++;
      if (n == 2 * d) first_trial = dac_code;
      if (chan_sel != ch0) chan_moved = 1;
      ctrl_wr = 1'b0; mode_wr = 1'b0;
      if (disturb && n == 5 * d) begin
        ctrl_wr = 1'b1; ctrl_wdata = 8'h47;
        mode_wr = 1'b1; mode_wdata = 8'h80;
      end
      if (collide && n == 17 * d - 1) begin
        ctrl_wr = 1'b1; ctrl_wdata = 8'h43;
      end
      @(negedge clk); n++;
    end
    ctrl_wr = 1'b0; mode_wr = 1'b0;
    len = n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int len, sf, sl, ft;
    bit mv;
    logic [11:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rdata[6] == 1'b1, "R4 reset done", ctrl_rdata[6], 1);
    chk(result == 12'h000, "R5 reset result", result, 0);
    chk(sample == 1'b0, "R2 reset sample", sample, 0);
    chk(mode_rdata == 8'h80, "R6 reset mode", mode_rdata, 8'h80);

    // divider sweep R1 R2 R3 R5 R8
    for (int s = 0; s < 8; s++) begin
      int d;
      d = 1 << s;
      vin = 12'((s * 517 + 300) & 12'hFFF);
      wr_mode(8'h80 | 8'(s));
      chk(mode_rdata == (8'h80 | 8'(s)), "R6 mode readback", mode_rdata, 8'h80 | s);
      run_conv(4'(s), d, 0, 0, len, sf, sl, ft, mv);
      chk(len == 17 * d, "R1 R3 frame length", len, 17 * d);
      chk(sf == d, "R2 sample start", sf, d);
      chk(sl == d, "R2 sample width", sl, d);
      chk(ft == 12'h800, "R5 first trial", ft, 12'h800);
      chk(result == vin, "R5 result", result, vin);
      chk(chan_sel == 4'(s), "R8 channel", chan_sel, s);
    end

    // exhaustive input sweep at divide-by-1, R5
    wr_mode(8'h80);
    for (int v = 0; v < 4096; v++) begin
      vin = 12'(v);
      run_conv(4'd9, 1, 0, 0, len, sf, sl, ft, mv);
      chk(result == vin && len == 17, "R5 sweep result", result, v);
    end
    chk(chan_sel == 4'd9, "R8 channel 9", chan_sel, 9);

    // out-of-range channel R8
    run_conv(4'd12, 1, 0, 0, len, sf, sl, ft, mv);
    chk(chan_sel == 4'd0, "R8 channel clamp", chan_sel, 0);
    chk(ctrl_rdata[3:0] == 4'd12, "R8 channel readback", ctrl_rdata[3:0], 12);

    // start and register rewrites mid-frame R7
    wr_mode(8'h83);
    vin = 12'hA5C;
    run_conv(4'd5, 8, 1, 0, len, sf, sl, ft, mv);
    chk(len == 136, "R7 frame length kept", len, 136);
    chk(!mv && chan_sel == 4'd5, "R7 channel held", chan_sel, 5);
    chk(result == vin, "R7 result", result, vin);
    chk(ctrl_rdata[3:0] == 4'd7, "R8 readback after rewrite", ctrl_rdata[3:0], 7);

    // bad resolution code R6
    wr_mode(8'h62);
    keep = result;
    vin = 12'h123;
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = 8'h41;
    @(negedge clk); ctrl_wr = 1'b0;
    sl = 0; sf = 0;
    for (int i = 0; i < 60; i++) begin
      if (!ctrl_rdata[6]) sf++;
      if (sample) sl++;
      @(negedge clk);
    end
    chk(sf == 0, "R6 done held", sf, 0);
    chk(sl == 0, "R6 no sample", sl, 0);
    chk(result == keep, "R6 result unchanged", result, keep);
    wr_mode(8'h80);
    run_conv(4'd1, 1, 0, 0, len, sf, sl, ft, mv);
    chk(len == 17 && result == vin, "R6 start after fix", len, 17);

    // start on the completing cycle R9
    wr_mode(8'h82);
    vin = 12'h7FF;
    run_conv(4'd2, 4, 0, 1, len, sf, sl, ft, mv);
    chk(len == 68, "R9 frame length", len, 68);
    sl = 0; sf = 0;
    for (int i = 0; i < 80; i++) begin
      if (!ctrl_rdata[6]) sf++;
      if (sample) sl++;
      @(negedge clk);
    end
    chk(sf == 0, "R9 done stays set", sf, 0);
    chk(sl == 0, "R9 no new sample", sl, 0);
    chk(chan_sel == 4'd2, "R9 channel kept", chan_sel, 2);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule